// File: doc/BRIEF.md
# Dual-Cluster Stream Steering and Ordered Merge

This block sits between a branch-directed fetch stage and the instruction queue of a decoupled front end. Each incoming descriptor names one instruction stream: a sequence number, a length in instructions, and a base value. The block places each stream on one of two symmetric decode clusters. Every cluster has its own descriptor queue, a three-wide decode stage and its own queue of decoded instructions. While one cluster works on one stream, the other can work on a different, later stream at the same time.

The decode stage is a timing placeholder. Instruction `i` of a stream is reported with the payload `base + i`, and the last instruction of the stream carries an end flag. On the output side, an ordered merge drains the two decoded queues strictly by sequence number. It fills up to six output slots per cycle, so the consumer sees program order no matter which cluster finished first. A static mode input turns the second cluster off. A flush input drops all outstanding work in one cycle.

Top module: `dual_decode_front`

## Requirements
- R1: A descriptor is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while `flush` is high and while the input queue of the chosen cluster is full. That queue holds IQ_DEPTH = 4 descriptors and credits a slot only on the edge after its stream finishes decoding. No accepted stream is lost.
- R2: Each cluster has a pending count: the instructions accepted into it minus the instructions delivered from it. Each stream goes to the cluster with the smaller pending count, and a tie goes to cluster 0. `out_src` reports the cluster, with 0 meaning cluster 0.
- R3: All instructions of one stream are decoded by the same cluster, so they all carry the same `out_src`.
- R4: While `single_mode` is 1, every stream goes to cluster 0 and cluster 1 produces no decoded instructions.
- R5: A stream with length L (1 to 15) and base B delivers exactly L instructions. Instruction i carries `out_data` = B + i (modulo 2^16) and `out_seq` equal to the stream's sequence number. `out_last` is 1 only on instruction L-1.
- R6: Streams are delivered in ascending sequence order (modulo 64), starting at 0 after reset or flush. Every instruction of one stream is delivered before any instruction of the next.
- R7: Up to six instructions are delivered per cycle. The valid slots are contiguous from slot 0, so `out_valid` is a thermometer code, and a lower slot holds an earlier instruction.
- R8: Each cluster decodes at most three instructions per cycle. A lone 15-instruction stream accepted by an idle block delivers nothing in the cycle after acceptance, then exactly three instructions in each of the next five cycles.
- R9: When the oldest stream ends inside a cycle, the remaining slots of that cycle are filled from the next stream in sequence, even when that stream sits on the other cluster. Two clusters can therefore deliver six instructions in one cycle.
- R10: A flush discards all queued and in-progress work in both clusters. It delivers nothing in the flush cycle or the cycle after, returns the expected sequence number to 0 and clears both pending counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drop all outstanding streams this cycle |
| single_mode | input | 1 | 1 disables cluster 1 (change only together with a flush) |
| in_valid | input | 1 | Stream descriptor present |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_seq | input | 6 | Stream sequence number, consecutive modulo 64 |
| in_len | input | 4 | Stream length in instructions, 1 to 15 |
| in_base | input | 16 | Payload of the stream's first instruction |
| out_valid | output | 6 | Per-slot valid, thermometer from slot 0 |
| out_data | output | 96 | Per-slot payload, slot k in bits 16k+15:16k |
| out_seq | output | 36 | Per-slot stream sequence number, slot k in bits 6k+5:6k |
| out_last | output | 6 | Per-slot end-of-stream flag |
| out_src | output | 6 | Per-slot decoding cluster |

## Verification
The bench targets the handover between streams inside one output cycle. A merge that stopped at a stream end would deliver three instructions where six are expected. A merge that looked only at the queue it just read would stall or swap streams, which the in-order scoreboard reports as a sequence mismatch. The bench also tests steering against its own model of the pending counts: a tie-break toward the wrong cluster, or a stale count, shows up as a wrong `out_src`. Finally it probes flush and the input-queue limit. A flush that left the sequence counter or a queue untouched would hang or misorder the next stream. A queue that credited its slot early would accept a descriptor where the bench expects a refusal.

// File: rtl/dfe_pkg.sv
// Shared widths and record types of the dual-cluster decode front.
// Assumes two clusters; the merge walks both by index.
package dfe_pkg;
    localparam int SEQ_W  = 6;   // stream sequence number width
    localparam int LEN_W  = 4;   // stream length field width
    localparam int DATA_W = 16;  // placeholder payload width
    localparam int DEC_W  = 3;   // decode width of one cluster
    localparam int MRG_W  = 6;   // merge output slots per cycle
    localparam int NCL    = 2;   // number of clusters
    localparam int SRC_W  = $clog2(NCL);

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] base;
    } desc_t;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] data;
        logic              last;
    } uop_t;
endpackage

// File: rtl/desc_queue.sv
// Circular descriptor queue, one push and one pop per cycle.
// Assumes DEPTH is a power of two; flush empties it in one cycle.
module desc_queue
    import dfe_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  push,
    input  desc_t din,
    input  logic  pop,
    output desc_t dout,
    output logic  empty,
    output logic  full
);
    desc_t          mem [DEPTH];
    logic [AW-1:0]  rd_q, wr_q;
    logic [CW-1:0]  cnt_q;

    // storage write on push
    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + AW'(1);
            if (pop)  rd_q <= rd_q + AW'(1);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // head and status view
    always_comb begin
        dout  = mem[rd_q];
        empty = (cnt_q == '0);
        full  = (cnt_q == CW'(DEPTH));
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/decode_cluster.sv
// One decode cluster: descriptor queue, three-wide placeholder decode
// and a decoded-instruction queue read up to MRG_W entries per cycle.
// Assumes OQ_DEPTH is a power of two and the reader never pops more
// than oq_cnt entries. The decode does not count this cycle's pops as
// free space, which keeps the merge off the decode path.
module decode_cluster
    import dfe_pkg::*;
#(
    parameter int IQ_DEPTH = 4,
    parameter int OQ_DEPTH = 8,
    localparam int OAW = $clog2(OQ_DEPTH),
    localparam int OCW = $clog2(OQ_DEPTH + 1),
    localparam int PW  = $clog2(MRG_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           enable,
    input  logic           push,
    input  desc_t          din,
    output logic           iq_full,
    input  logic [PW-1:0]  pop_cnt,
    output uop_t           heads [MRG_W],
    output logic [OCW-1:0] oq_cnt
);
    desc_t           hd;
    logic            iq_empty, iq_pop;
    logic [LEN_W-1:0] done_q;
    uop_t            mem [OQ_DEPTH];
    logic [OAW-1:0]  rd_q, wr_q;
    int              n;
    uop_t            wr_u [DEC_W];

    desc_queue #(.DEPTH(IQ_DEPTH)) u_iq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .din   (din),
        .pop   (iq_pop),
        .dout  (hd),
        .empty (iq_empty),
        .full  (iq_full)
    );

    // decode count this cycle and the entries it produces
    always_comb begin
        int remain;
        int space;
        remain = int'(hd.len) - int'(done_q);
        space  = OQ_DEPTH - int'(oq_cnt);
        n = DEC_W;
        if (remain < n) n = remain;
        if (space < n)  n = space;
        if (!enable || iq_empty || flush) n = 0;
        iq_pop = (n > 0) && (int'(done_q) + n == int'(hd.len));
        for (int i = 0; i < DEC_W; i++) begin
            wr_u[i].seq  = hd.seq;
            wr_u[i].data = hd.base + DATA_W'(int'(done_q) + i);
            wr_u[i].last = (int'(done_q) + i == int'(hd.len) - 1);
        end
    end

    // decoded-queue storage write
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEC_W; i++) begin
            if (i < n) mem[wr_q + OAW'(i)] <= wr_u[i];
        end
    end

    // pointers, occupancy and stream progress
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q   <= '0;
            wr_q   <= '0;
            oq_cnt <= '0;
            done_q <= '0;
        end else begin
            wr_q   <= wr_q + OAW'(n);
            rd_q   <= rd_q + OAW'(pop_cnt);
            oq_cnt <= oq_cnt + OCW'(n) - OCW'(pop_cnt);
            done_q <= iq_pop ? '0 : done_q + LEN_W'(n);
        end
    end

    // oldest-first view for the merge
    always_comb begin
        for (int i = 0; i < MRG_W; i++) heads[i] = mem[rd_q + OAW'(i)];
    end

    // R6
    oq_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(oq_cnt) <= OQ_DEPTH);
    // R6
    pop_within_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_cnt) <= int'(oq_cnt));
    // R4
    disabled_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> oq_cnt <= $past(oq_cnt));
endmodule

// File: rtl/ordered_merge.sv
// Ordered merge: fills up to MRG_W slots per cycle, always taking the
// entry of the oldest outstanding stream from whichever cluster holds
// it, and moving to the next sequence number after an end flag.
// Assumes each cluster queue is internally in stream order.
module ordered_merge
    import dfe_pkg::*;
#(
    parameter int OQ_DEPTH = 8,
    localparam int OCW = $clog2(OQ_DEPTH + 1),
    localparam int PW  = $clog2(MRG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  uop_t             heads [NCL][MRG_W],
    input  logic [OCW-1:0]   cnt [NCL],
    output logic [PW-1:0]    pop [NCL],
    output uop_t             slot_u [MRG_W],
    output logic [MRG_W-1:0] slot_v,
    output logic [SRC_W-1:0] slot_src [MRG_W]
);
    logic [SEQ_W-1:0] exp_q, exp_d;

    // slot-by-slot walk in sequence order across both queues
    always_comb begin
        int   p [NCL];
        logic blocked;
        logic hit;
        logic [SEQ_W-1:0] e;
        e = exp_q;
        blocked = 1'b0;
        for (int c = 0; c < NCL; c++) p[c] = 0;
        for (int k = 0; k < MRG_W; k++) begin
            slot_v[k]   = 1'b0;
            slot_u[k]   = '0;
            slot_src[k] = '0;
            hit = 1'b0;
            for (int c = 0; c < NCL; c++) begin
                if (!blocked && !hit && p[c] < int'(cnt[c])) begin
                    if (heads[c][p[c]].seq == e) begin
                        hit         = 1'b1;
                        slot_u[k]   = heads[c][p[c]];
                        slot_src[k] = SRC_W'(c);
                        p[c]        = p[c] + 1;
                    end
                end
            end
            if (hit) begin
                slot_v[k] = !flush;
                if (slot_u[k].last) e = e + SEQ_W'(1);
            end else begin
                blocked = 1'b1;
            end
        end
        for (int c = 0; c < NCL; c++) pop[c] = flush ? '0 : PW'(p[c]);
        exp_d = e;
    end

    // expected sequence register
    always_ff @(posedge clk) begin
        if (!rst_n || flush) exp_q <= '0;
        else                 exp_q <= exp_d;
    end

    // R7
    slots_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_v & (slot_v + MRG_W'(1))) == '0);
    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> slot_v == '0);
endmodule

// File: rtl/dual_decode_front.sv
// Top: steers stream descriptors to the less loaded of two decode
// clusters (ties to cluster 0, cluster 1 off in single mode), tracks
// per-cluster pending instruction counts and merges the decoded
// output in program order. Assumes consecutive sequence numbers,
// lengths of at least one, and single_mode changing only with flush.
module dual_decode_front
    import dfe_pkg::*;
#(
    parameter int IQ_DEPTH = 4,
    parameter int OQ_DEPTH = 8,
    localparam int OCW    = $clog2(OQ_DEPTH + 1),
    localparam int PW     = $clog2(MRG_W + 1),
    localparam int MAXLEN = (1 << LEN_W) - 1,
    localparam int LDW    = $clog2((IQ_DEPTH + 1) * MAXLEN + OQ_DEPTH + 1) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      single_mode,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [SEQ_W-1:0]          in_seq,
    input  logic [LEN_W-1:0]          in_len,
    input  logic [DATA_W-1:0]         in_base,
    output logic [MRG_W-1:0]          out_valid,
    output logic [MRG_W*DATA_W-1:0]   out_data,
    output logic [MRG_W*SEQ_W-1:0]    out_seq,
    output logic [MRG_W-1:0]          out_last,
    output logic [MRG_W*SRC_W-1:0]    out_src
);
    desc_t            in_desc;
    logic [LDW-1:0]   load [NCL];
    logic [NCL-1:0]   iq_full, push, cl_en;
    logic [PW-1:0]    pop [NCL];
    logic [OCW-1:0]   oq_cnt [NCL];
    uop_t             heads [NCL][MRG_W];
    uop_t             slot_u [MRG_W];
    logic [MRG_W-1:0] slot_v;
    logic [SRC_W-1:0] slot_src [MRG_W];
    logic [SRC_W-1:0] tgt;

    // steering choice and input handshake
    always_comb begin
        in_desc  = '{seq: in_seq, len: in_len, base: in_base};
        tgt      = single_mode ? '0 : SRC_W'(load[1] < load[0]);
        in_ready = !flush && !iq_full[tgt];
    end

    for (genvar c = 0; c < NCL; c++) begin : g_cl
        assign push[c]  = in_valid && in_ready && (int'(tgt) == c);
        if (c == 0) begin : g_always_on
            assign cl_en[c] = 1'b1;
        end else begin : g_mode_gated
            assign cl_en[c] = !single_mode;
        end

        decode_cluster #(.IQ_DEPTH(IQ_DEPTH), .OQ_DEPTH(OQ_DEPTH)) u_cluster (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .enable  (cl_en[c]),
            .push    (push[c]),
            .din     (in_desc),
            .iq_full (iq_full[c]),
            .pop_cnt (pop[c]),
            .heads   (heads[c]),
            .oq_cnt  (oq_cnt[c])
        );

        // pending instruction count of this cluster
        always_ff @(posedge clk) begin
            if (!rst_n || flush) load[c] <= '0;
            else load[c] <= load[c] + (push[c] ? LDW'(in_len) : '0) - LDW'(pop[c]);
        end
    end

    ordered_merge #(.OQ_DEPTH(OQ_DEPTH)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .heads    (heads),
        .cnt      (oq_cnt),
        .pop      (pop),
        .slot_u   (slot_u),
        .slot_v   (slot_v),
        .slot_src (slot_src)
    );

    // flatten merge slots onto the output ports
    always_comb begin
        out_valid = slot_v;
        for (int k = 0; k < MRG_W; k++) begin
            out_data[k*DATA_W +: DATA_W] = slot_u[k].data;
            out_seq[k*SEQ_W +: SEQ_W]    = slot_u[k].seq;
            out_last[k]                  = slot_u[k].last;
            out_src[k*SRC_W +: SRC_W]    = slot_src[k];
        end
    end
endmodule

// File: tb/dual_decode_front_bench.sv
`timescale 1ns/1ps
module dual_decode_front_bench;
    import dfe_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, single_mode = 1'b0, in_valid = 1'b0;
    logic in_ready;
    logic [SEQ_W-1:0] in_seq = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic [DATA_W-1:0] in_base = '0;
    logic [MRG_W-1:0] out_valid, out_last;
    logic [MRG_W*DATA_W-1:0] out_data;
    logic [MRG_W*SEQ_W-1:0] out_seq;
    logic [MRG_W*SRC_W-1:0] out_src;

    dual_decode_front u_dual_decode_front (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single_mode(single_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_seq(in_seq), .in_len(in_len),
        .in_base(in_base), .out_valid(out_valid), .out_data(out_data),
        .out_seq(out_seq), .out_last(out_last), .out_src(out_src)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] data;
        logic              last;
        int                cl;
    } exp_t;

    exp_t sb[$];
    int mload [2];
    logic [SEQ_W-1:0] next_seq = '0;
    int n_chk = 0, n_bad = 0, cyc_del = 0;
    bit cyc_acc = 0, prev_fl = 0, fin = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int steer_pick();
        if (single_mode) return 0;
        return (mload[1] < mload[0]) ? 1 : 0;
    endfunction

    // one cycle: drive at negedge, observe after settling, update model
    task automatic cycle(input bit v, input logic [LEN_W-1:0] len, input logic [DATA_W-1:0] base, input bit fl);
        @(negedge clk);
        in_valid = v; in_len = len; in_base = base; in_seq = next_seq; flush = fl;
        #1;
        cyc_del = 0;
        chk((out_valid & (out_valid + 6'd1)) == 6'd0, "R7", "valid slots not packed", int'(out_valid), 0);
        if (fl) begin
            chk(out_valid == 6'd0, "R10", "output during flush", int'(out_valid), 0);
            chk(in_ready == 1'b0, "R1", "ready during flush", int'(in_ready), 0);
        end
        if (prev_fl) chk(out_valid == 6'd0, "R10", "output after flush", int'(out_valid), 0);
        cyc_acc = v && in_ready;
        if (cyc_acc) begin
            int cl;
            cl = steer_pick();
            for (int i = 0; i < int'(len); i++) begin
                exp_t e;
                e.seq = next_seq; e.data = base + DATA_W'(i);
                e.last = (i == int'(len) - 1); e.cl = cl;
                sb.push_back(e);
            end
            mload[cl] += int'(len);
            next_seq = next_seq + SEQ_W'(1);
        end
        for (int k = 0; k < MRG_W; k++) begin
            if (out_valid[k]) begin
                cyc_del++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R6", "instruction with nothing outstanding", k, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(out_seq[k*SEQ_W +: SEQ_W] == e.seq, "R6", "stream order",
                        int'(out_seq[k*SEQ_W +: SEQ_W]), int'(e.seq));
                    chk(out_data[k*DATA_W +: DATA_W] == e.data, "R5", "payload",
                        int'(out_data[k*DATA_W +: DATA_W]), int'(e.data));
                    chk(out_last[k] == e.last, "R5", "end flag", int'(out_last[k]), int'(e.last));
                    if (single_mode)
                        chk(int'(out_src[k]) == 0, "R4", "cluster in single mode", int'(out_src[k]), 0);
                    else
                        chk(int'(out_src[k]) == e.cl, "R3", "cluster of stream (R2 steering)",
                            int'(out_src[k]), e.cl);
                    mload[e.cl] -= 1;
                end
            end
        end
        if (fl) begin
            sb.delete(); mload[0] = 0; mload[1] = 0; next_seq = '0;
        end
        prev_fl = fl;
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && sb.size() != 0; i++) cycle(1'b0, '0, '0, 1'b0);
        chk(sb.size() == 0, "R6", "instructions never delivered", sb.size(), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL R6 watchdog: actual %0d cycles expected completion", 150000);
            summary();
            $finish;
        end
    end

    initial begin
        int dl [8];
        bit acc [7];
        logic [LEN_W-1:0] plen;
        logic [DATA_W-1:0] pbase;
        void'($urandom(32'd20240611));
        mload[0] = 0; mload[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        cycle(1'b0, '0, '0, 1'b0);
        chk(out_valid == 6'd0, "R6", "output after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

        // R8: lone 15-long stream, three per cycle from the second cycle on
        cycle(1'b1, 4'd15, 16'h1000, 1'b0);
        dl[0] = cyc_del;
        for (int j = 1; j < 8; j++) begin cycle(1'b0, '0, '0, 1'b0); dl[j] = cyc_del; end
        chk(dl[1] == 0, "R8", "delivery one cycle after accept", dl[1], 0);
        for (int j = 2; j < 7; j++) chk(dl[j] == 3, "R8", "per-cycle decode rate", dl[j], 3);
        chk(dl[7] == 0, "R8", "delivery after stream end", dl[7], 0);

        // R9: six-long stream on cluster 0, three-long on cluster 1, six in one cycle
        cycle(1'b1, 4'd6, 16'h2000, 1'b0); dl[0] = cyc_del;
        cycle(1'b1, 4'd3, 16'h3000, 1'b0); dl[1] = cyc_del;
        cycle(1'b0, '0, '0, 1'b0); dl[2] = cyc_del;
        cycle(1'b0, '0, '0, 1'b0); dl[3] = cyc_del;
        chk(dl[2] == 3, "R9", "first cycle of oldest stream", dl[2], 3);
        chk(dl[3] == 6, "R9", "merged cycle across streams", dl[3], 6);
        drain();

        // R5: payload wrap at the top of the range
        cycle(1'b1, 4'd5, 16'hFFFE, 1'b0);
        drain();

        // R1: single mode, queue of four fills behind a 15-long stream
        single_mode = 1'b1;
        cycle(1'b0, '0, '0, 1'b1);
        for (int j = 0; j < 7; j++) begin
            cycle(1'b1, 4'd15, 16'(16'h4000 + j), 1'b0);
            acc[j] = cyc_acc;
        end
        for (int j = 0; j < 7; j++)
            chk(acc[j] == ((j == 4 || j == 5) ? 1'b0 : 1'b1), "R1", "accept pattern",
                int'(acc[j]), (j == 4 || j == 5) ? 0 : 1);
        drain();

        // R10: flush with work in flight, then restart at sequence 0 on cluster 0
        single_mode = 1'b0;
        cycle(1'b0, '0, '0, 1'b1);
        cycle(1'b1, 4'd10, 16'h5000, 1'b0);
        cycle(1'b1, 4'd10, 16'h6000, 1'b0);
        cycle(1'b0, '0, '0, 1'b0);
        cycle(1'b0, '0, '0, 1'b1);
        cycle(1'b1, 4'd2, 16'h7000, 1'b0);
        chk(cyc_acc == 1'b1, "R10", "accept after flush", int'(cyc_acc), 1);
        drain();

        // random phases: both modes, long streams, then dense short streams
        for (int ph = 0; ph < 3; ph++) begin
            single_mode = (ph == 1);
            cycle(1'b0, '0, '0, 1'b1);
            plen = 4'(1 + $urandom % 15); pbase = 16'($urandom);
            for (int i = 0; i < 3000; i++) begin
                bit v, fl;
                v  = (ph == 2) ? 1'b1 : (($urandom % 10) < 7);
                fl = (($urandom % 500) == 0);
                cycle(v, plen, pbase, fl);
                if (cyc_acc) begin
                    plen  = (ph == 2) ? 4'(1 + $urandom % 2) : 4'(1 + $urandom % 15);
                    pbase = 16'($urandom);
                end
            end
            drain();
        end

        fin = 1'b1;
        summary();
        $finish;
    end
endmodule